// File: doc/BRIEF.md
# Escaped-Delimiter Payload Extractor

This block takes a raw byte stream from a serial link and pulls out the payload of the frames it carries. Each frame is wrapped in a delimiter byte (0x02) at both ends. Inside a frame, a payload byte that equals the delimiter or the escape byte (0x10) is sent after an escape byte. The extractor removes the delimiters and the escapes. Payload bytes go out on a valid/ready stream. A one-cycle strobe marks the byte on which a frame closes.

The block sits between a byte receiver and whatever consumes frames. It holds three pieces of state across bytes: an escape-pending flag, an in-frame flag and a saturating payload length counter. It decides for each byte whether to pass it, drop it, or treat it as a frame boundary. It adds no latency: an input byte is consumed in any cycle where the input is valid and the consumer is ready. A passed byte appears on the output in that same cycle. A dropped byte still needs the consumer to be ready before it is taken. The recovery rules matter in practice. Two delimiters in a row with nothing between them restart the frame instead of producing an empty one. An escape seen outside a frame stays armed until a delimiter clears it.

Top module: `esc_frame_extract`

## Requirements
- R1: After reset the block is outside a frame with no escape pending: `out_valid` and `frame_end` are 0, and an ordinary byte sent first is not passed.
- R2: `in_ready` follows `out_ready`. A byte is consumed only when `in_valid` and `out_ready` are both 1. While `out_ready` is 0 no state changes and `frame_end` stays 0.
- R3: Outside a frame, a byte other than 0x02 or 0x10 is dropped: `out_valid` stays 0.
- R4: An unescaped 0x02 outside a frame is dropped and opens a frame.
- R5: Inside a frame, a byte other than 0x02 or 0x10 is passed unchanged on `out_byte`, with `out_valid` high, in the cycle it is presented, and the length counter counts it.
- R6: A 0x10 arriving with no escape pending is dropped and arms the escape.
- R7: Inside a frame, a 0x10 or 0x02 arriving with the escape armed is passed as payload, counted, and clears the escape.
- R8: An unescaped 0x02 inside a frame with a nonzero length is not passed. It raises `frame_end` for exactly the cycle in which it is consumed, leaves the frame and resets the length.
- R9: An unescaped 0x02 inside a frame with zero length is dropped without `frame_end`, and the block stays in the frame. A repeated delimiter therefore restarts the frame.
- R10: Outside a frame, a 0x10 arriving with the escape armed is dropped and leaves the escape armed.
- R11: Outside a frame, a 0x02 arriving with the escape armed is dropped, clears the escape and does not open a frame.
- R12: A byte other than 0x02 or 0x10 leaves the escape flag as it is, both inside and outside a frame.
- R13: The length counter saturates at its maximum (255 by default) instead of wrapping. A frame of exactly 256 payload bytes still closes with `frame_end` on the next unescaped 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Raw link byte |
| in_valid | input | 1 | Raw byte is present |
| in_ready | output | 1 | Raw byte is taken this cycle if valid |
| out_byte | output | 8 | Payload byte |
| out_valid | output | 1 | Payload byte is present |
| out_ready | input | 1 | Consumer accepts a payload byte |
| frame_end | output | 1 | Pulse: closing delimiter consumed this cycle |

## Verification
The closing strobe and output backpressure can meet in one cycle. A delimiter that would close a frame is held on the input while `out_ready` is low, and the bench expects `frame_end` to stay low and the frame to remain open. Once `out_ready` rises, the same delimiter must raise `frame_end` in that cycle and in no later one. The escape-armed state can also meet an ordinary byte inside a frame. The bench shows that the ordinary byte is passed while the escape stays armed, by checking that a following 0x02 comes out as payload and does not close the frame.

// File: rtl/esc_frame_extract.sv
module esc_frame_extract #(
  parameter int          LEN_W = 8,
  parameter logic [7:0]  DELIM = 8'h02,
  parameter logic [7:0]  ESC   = 8'h10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_byte,
  input  logic       in_valid,
  output logic       in_ready,
  output logic [7:0] out_byte,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       frame_end
);

  logic             in_frame, esc_pend;
  logic [LEN_W-1:0] len;
  logic             in_frame_n, esc_pend_n;
  logic [LEN_W-1:0] len_n;

  logic fire, is_delim, is_esc, len_zero, len_full, emit, close;

  assign fire     = in_valid & out_ready;
  assign is_delim = (in_byte == DELIM);
  assign is_esc   = (in_byte == ESC);
  assign len_zero = (len == '0);
  assign len_full = &len;

  assign emit  = in_frame & (esc_pend | (~is_delim & ~is_esc));
  assign close = in_frame & is_delim & ~esc_pend & ~len_zero;

  assign in_ready  = out_ready;
  assign out_byte  = in_byte;
  assign out_valid = in_valid & emit;
  assign frame_end = fire & close;

  always_comb begin
    esc_pend_n = esc_pend;
    in_frame_n = in_frame;
    len_n      = len;
    if (is_esc) begin
      esc_pend_n = esc_pend ? ~in_frame : 1'b1;
    end else if (is_delim) begin
      esc_pend_n = 1'b0;
      if (!esc_pend) in_frame_n = ~in_frame | len_zero;
    end
    if (close)
      len_n = '0;
    else if (emit && !len_full)
      len_n = len + LEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      esc_pend <= 1'b0;
      len      <= '0;
    end else if (fire) begin
      in_frame <= in_frame_n;
      esc_pend <= esc_pend_n;
      len      <= len_n;
    end
  end

endmodule

// File: rtl/esc_frame_extract_chk.sv
module esc_frame_extract_chk #(
  parameter int         LEN_W = 8,
  parameter logic [7:0] DELIM = 8'h02,
  parameter logic [7:0] ESC   = 8'h10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       in_byte,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             frame_end,
  input logic             in_frame,
  input logic             esc_pend,
  input logic [LEN_W-1:0] len
);

  logic fire;
  assign fire = in_valid & in_ready;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(in_frame) && $stable(esc_pend) && $stable(len)));

  assert_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_frame && !esc_pend && in_byte == DELIM) |=> in_frame);

  assert_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !esc_pend && in_byte == ESC) |=> esc_pend);

  assert_end_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (!in_frame && len == '0));

  assert_end_no_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (!out_valid && in_frame));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_frame && !esc_pend && len == '0 && in_byte == DELIM) |=> in_frame);

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_frame && esc_pend && in_byte == ESC) |=> (esc_pend && !in_frame));

  assert_saturate_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_valid && (&len)) |=> (&len));

endmodule

bind esc_frame_extract esc_frame_extract_chk #(.LEN_W(LEN_W), .DELIM(DELIM), .ESC(ESC)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .frame_end(frame_end),
  .in_frame(in_frame), .esc_pend(esc_pend), .len(len)
);

// File: tb/esc_frame_extract_tb_top.sv
module esc_frame_extract_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_valid = 1'b0;
  logic       out_ready = 1'b0;
  logic       in_ready, out_valid, frame_end;
  logic [7:0] out_byte;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  esc_frame_extract dut_i (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
    .in_ready(in_ready), .out_byte(out_byte), .out_valid(out_valid),
    .out_ready(out_ready), .frame_end(frame_end)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push(input logic [7:0] b, input bit ev, input bit ee, input string tag);
    @(negedge clk);
    in_byte = b; in_valid = 1'b1; out_ready = 1'b1;
    #1;
    check({tag, " out_valid"}, out_valid, ev);
    if (ev) check({tag, " out_byte"}, out_byte, b);
    check({tag, " frame_end"}, frame_end, ee);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    #1;
    check("idle out_valid", out_valid, 0);
    check("idle frame_end", frame_end, 0);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check("R1 out_valid after reset", out_valid, 0);
    check("R1 frame_end after reset", frame_end, 0);
    push(8'h41, 0, 0, "R1 first byte dropped");
    idle();
  endtask

  task automatic t_outside();
    do_reset();
    push(8'h33, 0, 0, "R3 outside drop a");
    push(8'hFF, 0, 0, "R3 outside drop b");
    push(8'h00, 0, 0, "R3 outside drop c");
    idle();
  endtask

  task automatic t_basic();
    do_reset();
    push(8'h02, 0, 0, "R4 open");
    push(8'hA5, 1, 0, "R5 pass a");
    push(8'h5A, 1, 0, "R5 pass b");
    push(8'h02, 0, 1, "R8 close");
    idle();
    push(8'h77, 0, 0, "R8 left frame");
    idle();
  endtask

  task automatic t_backpressure();
    do_reset();
    push(8'h02, 0, 0, "R2 open");
    @(negedge clk);
    in_byte = 8'h41; in_valid = 1'b1; out_ready = 1'b0;
    #1;
    check("R2 in_ready low", in_ready, 0);
    check("R2 out_valid shown", out_valid, 1);
    push(8'h41, 1, 0, "R2 taken");
    @(negedge clk);
    in_byte = 8'h02; in_valid = 1'b1; out_ready = 1'b0;
    #1;
    check("R2 no end while stalled", frame_end, 0);
    @(negedge clk);
    #1;
    check("R2 still no end", frame_end, 0);
    push(8'h02, 0, 1, "R2 end after release");
    idle();
  endtask

  task automatic t_escape_in();
    do_reset();
    push(8'h02, 0, 0, "R4 open");
    push(8'h10, 0, 0, "R6 arm");
    push(8'h10, 1, 0, "R7 escaped esc");
    push(8'h10, 0, 0, "R6 arm again");
    push(8'h02, 1, 0, "R7 escaped delim");
    push(8'h02, 0, 1, "R7 cleared, delim closes");
    idle();
  endtask

  task automatic t_empty();
    do_reset();
    push(8'h02, 0, 0, "R9 open");
    push(8'h02, 0, 0, "R9 empty restart");
    push(8'h02, 0, 0, "R9 empty restart again");
    push(8'h61, 1, 0, "R9 still in frame");
    push(8'h02, 0, 1, "R9 close");
    idle();
  endtask

  task automatic t_esc_out_esc();
    do_reset();
    push(8'h10, 0, 0, "R10 arm outside");
    push(8'h10, 0, 0, "R10 escaped esc dropped");
    push(8'h02, 0, 0, "R10 still armed, delim absorbed");
    push(8'h41, 0, 0, "R10 frame not opened");
    push(8'h02, 0, 0, "R10 open now");
    push(8'h41, 1, 0, "R10 pass");
    idle();
  endtask

  task automatic t_esc_out_delim();
    do_reset();
    push(8'h10, 0, 0, "R11 arm outside");
    push(8'h02, 0, 0, "R11 escaped delim dropped");
    push(8'h41, 0, 0, "R11 not in frame");
    push(8'h02, 0, 0, "R11 escape cleared, opens");
    push(8'h41, 1, 0, "R11 pass");
    idle();
  endtask

  task automatic t_ord_keep();
    do_reset();
    push(8'h02, 0, 0, "R12 open");
    push(8'h10, 0, 0, "R12 arm");
    push(8'h41, 1, 0, "R12 ordinary passed");
    push(8'h02, 1, 0, "R12 escape still armed");
    push(8'h02, 0, 1, "R12 close");
    idle();
    push(8'h10, 0, 0, "R12 arm outside");
    push(8'h55, 0, 0, "R12 ordinary outside");
    push(8'h02, 0, 0, "R12 still armed outside");
    push(8'h41, 0, 0, "R12 no frame opened");
    idle();
  endtask

  task automatic t_sat();
    int errs;
    do_reset();
    push(8'h02, 0, 0, "R13 open");
    errs = bad;
    for (int i = 0; i < 256; i++) push(8'h55, 1, 0, "R13 payload");
    check("R13 payload run clean", bad - errs, 0);
    push(8'h02, 0, 1, "R13 close after 256");
    idle();
  endtask

  initial begin
    t_reset();
    t_outside();
    t_basic();
    t_backpressure();
    t_escape_in();
    t_empty();
    t_esc_out_esc();
    t_esc_out_delim();
    t_ord_keep();
    t_sat();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule